// File: doc/BRIEF.md
# Infrared Low-Speed Pulse Transmitter

This block sends 8-bit characters over an infrared link using the low-speed infrared physical-layer coding. A character is serialised as a start bit, eight data bits sent least-significant bit first, and a stop bit. Only the bits whose value is 0 produce light. Each such bit becomes a short active-low pulse that starts at the beginning of its bit slot. Bits of value 1, the stop bit and the idle line all leave the output high. The serial stream gates a pulse timer that is restarted at every bit boundary, so every pulse stays aligned to its slot.

Software uses a small register port to write bytes into a one-entry holding buffer and to set an enable and an interrupt mask. It reads a status byte with a buffer-empty flag and a transfer-complete flag, and it programs the pulse width as a numerator over a denominator, both counted in pulse-timer ticks. Two tick inputs pace the block. The baud tick arrives eight times per bit. The pulse tick arrives an integer multiple of that rate and is in phase with it. A byte that is queued while another is being sent goes out in the bit slot directly after the current stop bit.

Top module: `sir_pulse_tx`

## Requirements
- R1: A character is sent as a 0 start bit, then data bits 0 to 7 with the least-significant bit first, then a 1 stop bit.
- R2: A bit slot opens on the first baud tick after the transmitter is enabled. After that a slot opens on every eighth baud tick, and the serial bit does not change between slot openings.
- R3: `ir_tx_n` goes low only inside slots that carry a 0 bit. It stays high during 1 bits, the stop bit and idle.
- R4: After reset the pulse width is 1/8 of a bit: denominator 8, numerator 1. The pulse starts at the slot opening.
- R5: Register 3 holds the denominator and register 4 holds the numerator. A pulse lasts for the numerator's count of pulse ticks, counted from the slot opening. Examples: 3 of 16 with the pulse tick at twice the baud rate, or 1 of 64 with it at eight times the baud rate.
- R6: A numerator of 0 gives no pulse. A numerator greater than or equal to the denominator gives a pulse that fills the whole slot.
- R7: A byte written to register 0 moves to the shifter at the next slot opening in which the shifter is free. That move sets status bit 4 (buffer empty).
- R8: `irq` is high exactly when control bit 1 (mask) is set and the buffer is empty. It therefore rises on the clock after a byte moves to the shifter.
- R9: A byte queued while another is being sent starts its start bit in the slot right after the stop bit, with no idle slot in between.
- R10: Status bit 5 (complete) is set at the end of a stop bit. It stays set until status register 2 is read, and that read clears it.
- R11: Control bit 0 enables the transmitter. While it is clear the output stays high, the frame in progress and the slot counters reset, and a byte written to the buffer is kept until the transmitter is enabled again.
- R12: After reset `ir_tx_n` is high, `irq` is low and the status reads 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle strobe at eight times the bit rate |
| pulse_tick | input | 1 | One-cycle strobe at an integer multiple of the baud tick rate, in phase with it |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of register 2 clears the complete flag) |
| reg_addr | input | 3 | Register select: 0 data, 1 control, 2 status, 3 denominator, 4 numerator |
| reg_wdata | input | DW (8) | Write data |
| reg_rdata | output | DW (8) | Read data for `reg_addr`, combinational |
| irq | output | 1 | Buffer-empty interrupt, gated by the mask |
| ir_tx_n | output | 1 | Encoded optical output, active low |

## Verification
The line output changes on the clock edge that samples a baud tick opening a slot. The pulse then ends on the edge that samples the numerator-th pulse tick after it. The buffer-empty flag and `irq` change on that same slot-opening edge, and the complete flag on the edge that closes the stop bit. Register reads are combinational and are sampled inside the cycle in which they are strobed, while the clear-on-read takes effect at the next edge. The bench holds a behavioural model that is stepped on the same edges as the design. It compares the line and the interrupt in the middle of every cycle. It adds directed status reads and counts of low cycles per frame at the points where these results are due.

// File: rtl/sir_tx_pkg.sv
package sir_tx_pkg;

   typedef enum logic [2:0] {
      RA_DATA = 3'd0,
      RA_CTRL = 3'd1,
      RA_STAT = 3'd2,
      RA_DEN  = 3'd3,
      RA_NUM  = 3'd4
   } sir_reg_e;

   localparam int CTL_EN_BIT   = 0;
   localparam int CTL_IE_BIT   = 1;
   localparam int ST_EMPTY_BIT = 4;
   localparam int ST_DONE_BIT  = 5;

endpackage

// File: rtl/sir_tx_bitclk.sv
module sir_tx_bitclk #(
   parameter int OVS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic baud_tick,
   output logic bit_edge
);
   localparam int SW = (OVS > 1) ? $clog2(OVS) : 1;

   logic [SW-1:0] sub_q;
   logic [SW-1:0] sub_nx;

   assign bit_edge = en & baud_tick & (sub_q == '0);

   generate
      if ((1 << SW) == OVS) begin : g_pow2
         assign sub_nx = sub_q + 1'b1;
      end else begin : g_mod
         assign sub_nx = (sub_q == SW'(OVS - 1)) ? '0 : sub_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)         sub_q <= '0;
      else if (!en)       sub_q <= '0;
      else if (baud_tick) sub_q <= sub_nx;
   end
endmodule

// File: rtl/sir_tx_pulse_timer.sv
module sir_tx_pulse_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          bit_edge,
   input  logic          pulse_tick,
   input  logic [TW-1:0] den,
   input  logic [TW-1:0] num,
   output logic          pulse_on
);
   logic [TW-1:0] cnt_q;
   logic [TW-1:0] num_eff;

   // numerator above the period saturates to a full slot
   assign num_eff  = (num > den) ? den : num;
   assign pulse_on = (cnt_q < num_eff);

   always_ff @(posedge clk) begin
      if (!rst_n)                           cnt_q <= '0;
      else if (!en)                         cnt_q <= '0;
      else if (bit_edge)                    cnt_q <= '0;
      else if (pulse_tick && cnt_q != '1)   cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/sir_tx_framer.sv
module sir_tx_framer #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          bit_edge,
   input  logic          load_wr,
   input  logic [DW-1:0] load_data,
   output logic          busy,
   output logic          ser_bit,
   output logic          buf_full,
   output logic          frame_done
);
   localparam int LAST = DW + 1;
   localparam int IW   = $clog2(DW + 2);

   logic [DW-1:0] buf_q;
   logic          full_q;
   logic [DW-1:0] sh_q;
   logic [IW-1:0] idx_q;
   logic          busy_q;
   logic          take;

   assign frame_done = bit_edge & busy_q & (idx_q == IW'(LAST));
   assign take       = bit_edge & full_q & (!busy_q | frame_done);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q  <= '0;
         full_q <= 1'b0;
      end else if (load_wr) begin
         buf_q  <= load_data;
         full_q <= 1'b1;
      end else if (take) begin
         full_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         sh_q   <= '0;
      end else if (!en) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
      end else if (take) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
         sh_q   <= buf_q;
      end else if (frame_done) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
      end else if (bit_edge && busy_q) begin
         idx_q <= idx_q + 1'b1;
         if (idx_q != '0) sh_q <= sh_q >> 1;
      end
   end

   always_comb begin
      if (!busy_q)                    ser_bit = 1'b1;
      else if (idx_q == '0)           ser_bit = 1'b0;
      else if (idx_q <= IW'(DW))      ser_bit = sh_q[0];
      else                            ser_bit = 1'b1;
   end

   assign busy     = busy_q;
   assign buf_full = full_q;
endmodule

// File: rtl/sir_pulse_tx.sv
module sir_pulse_tx
   import sir_tx_pkg::*;
#(
   parameter int DW      = 8,
   parameter int TW      = 8,
   parameter int OVS     = 8,
   parameter int DEF_DEN = 8,
   parameter int DEF_NUM = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          baud_tick,
   input  logic          pulse_tick,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [2:0]    reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   output logic          irq,
   output logic          ir_tx_n
);
   generate
      if (DW < ST_DONE_BIT + 1) begin : g_bad_dw
         $error("sir_pulse_tx: DW too narrow for status bits");
      end
      if (TW > DW) begin : g_bad_tw
         $error("sir_pulse_tx: TW must not exceed DW");
      end
      if (OVS < 2) begin : g_bad_ovs
         $error("sir_pulse_tx: OVS must be at least 2");
      end
   endgenerate

   logic          en_q, ie_q, done_q;
   logic [TW-1:0] den_q, num_q;
   logic          bit_edge, pulse_on, busy, ser_bit, buf_full, frame_done;
   logic          wr_data, wr_ctrl, wr_den, wr_num, rd_stat;

   assign wr_data = reg_wr & (reg_addr == RA_DATA);
   assign wr_ctrl = reg_wr & (reg_addr == RA_CTRL);
   assign wr_den  = reg_wr & (reg_addr == RA_DEN);
   assign wr_num  = reg_wr & (reg_addr == RA_NUM);
   assign rd_stat = reg_rd & (reg_addr == RA_STAT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         ie_q  <= 1'b0;
         den_q <= TW'(DEF_DEN);
         num_q <= TW'(DEF_NUM);
      end else begin
         if (wr_ctrl) begin
            en_q <= reg_wdata[CTL_EN_BIT];
            ie_q <= reg_wdata[CTL_IE_BIT];
         end
         if (wr_den) den_q <= reg_wdata[TW-1:0];
         if (wr_num) num_q <= reg_wdata[TW-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          done_q <= 1'b0;
      else if (frame_done) done_q <= 1'b1;
      else if (rd_stat)    done_q <= 1'b0;
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_CTRL: begin
            reg_rdata[CTL_EN_BIT] = en_q;
            reg_rdata[CTL_IE_BIT] = ie_q;
         end
         RA_STAT: begin
            reg_rdata[ST_EMPTY_BIT] = ~buf_full;
            reg_rdata[ST_DONE_BIT]  = done_q;
         end
         RA_DEN:  reg_rdata = DW'(den_q);
         RA_NUM:  reg_rdata = DW'(num_q);
         default: reg_rdata = '0;
      endcase
   end

   sir_tx_bitclk #(.OVS(OVS)) u_bitclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en_q),
      .baud_tick (baud_tick),
      .bit_edge  (bit_edge)
   );

   sir_tx_pulse_timer #(.TW(TW)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en_q),
      .bit_edge   (bit_edge),
      .pulse_tick (pulse_tick),
      .den        (den_q),
      .num        (num_q),
      .pulse_on   (pulse_on)
   );

   sir_tx_framer #(.DW(DW)) u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en_q),
      .bit_edge   (bit_edge),
      .load_wr    (wr_data),
      .load_data  (reg_wdata),
      .busy       (busy),
      .ser_bit    (ser_bit),
      .buf_full   (buf_full),
      .frame_done (frame_done)
   );

   // serial high masks the timer: active-low wired-OR
   assign ir_tx_n = ~(busy & ~ser_bit & pulse_on);
   assign irq     = ie_q & ~buf_full;
endmodule

// File: rtl/sir_pulse_tx_chk.sv
module sir_pulse_tx_chk #(
   parameter int TW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          en_q,
   input logic          ie_q,
   input logic          busy,
   input logic          ser_bit,
   input logic          buf_full,
   input logic          done_q,
   input logic          bit_edge,
   input logic          irq,
   input logic          ir_tx_n,
   input logic          reg_rd,
   input logic [2:0]    reg_addr,
   input logic [TW-1:0] num_q
);
   assert_quiet_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> ir_tx_n);

   assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> ir_tx_n);

   assert_bit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !bit_edge) |=> $stable(ser_bit));

   assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($fell(buf_full) || $rose(ie_q)));

   assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !(reg_rd && reg_addr == 3'd2)) |=> done_q);

   assert_done_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(busy));

   assert_zero_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (num_q == '0) |-> ir_tx_n);
endmodule

bind sir_pulse_tx sir_pulse_tx_chk #(.TW(TW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en_q     (en_q),
   .ie_q     (ie_q),
   .busy     (busy),
   .ser_bit  (ser_bit),
   .buf_full (buf_full),
   .done_q   (done_q),
   .bit_edge (bit_edge),
   .irq      (irq),
   .ir_tx_n  (ir_tx_n),
   .reg_rd   (reg_rd),
   .reg_addr (reg_addr),
   .num_q    (num_q)
);

// File: tb/sir_pulse_tx_tb.sv
module sir_pulse_tx_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0, pulse_tick = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq, ir_tx_n;

   int n_chk = 0, n_fail = 0, cyc = 0, low_cnt = 0, gcnt = 0;
   int bdiv = 2, kmul = 1;
   bit finished = 1'b0;
   string cur_req = "R12";

   // behavioural reference state
   bit m_en, m_ie, m_full, m_done;
   logic [7:0] m_buf;
   int m_sub, m_cnt, m_den, m_num;
   bit q[$];

   sir_pulse_tx u_dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .pulse_tick(pulse_tick),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq), .ir_tx_n(ir_tx_n)
   );

   always #5 clk = ~clk;

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   // tick generator, in phase
   always @(negedge clk) begin
      gcnt++;
      baud_tick  = (gcnt % bdiv) == 0;
      pulse_tick = (gcnt % (bdiv / kmul)) == 0;
   end

   always @(negedge clk) if (rst_n && !ir_tx_n) low_cnt++;

   // reference model step
   always @(posedge clk) begin : model
      bit opn, fin;
      fin = 1'b0;
      if (!rst_n) begin
         m_en = 0; m_ie = 0; m_full = 0; m_done = 0; m_buf = '0;
         m_sub = 0; m_cnt = 0; m_den = 8; m_num = 1; q.delete();
      end else begin
         opn = m_en && baud_tick && (m_sub == 0);
         if (!m_en) begin
            m_sub = 0; m_cnt = 0; q.delete();
         end else begin
            if (baud_tick) m_sub = (m_sub + 1) % 8;
            if (opn) m_cnt = 0;
            else if (pulse_tick && m_cnt < 255) m_cnt++;
            if (opn) begin
               if (q.size() > 0) begin
                  void'(q.pop_front());
                  if (q.size() == 0) fin = 1'b1;
               end
               if (q.size() == 0 && m_full) begin
                  q.push_back(1'b0);
                  for (int i = 0; i < 8; i++) q.push_back(m_buf[i]);
                  q.push_back(1'b1);
                  m_full = 0;
               end
            end
         end
         if (reg_wr) begin
            case (reg_addr)
               3'd0: begin m_buf = reg_wdata; m_full = 1; end
               3'd1: begin m_en = reg_wdata[0]; m_ie = reg_wdata[1]; end
               3'd3: m_den = reg_wdata;
               3'd4: m_num = reg_wdata;
               default: ;
            endcase
         end
         if (fin) m_done = 1;
         else if (reg_rd && reg_addr == 3'd2) m_done = 0;
      end
   end

   // compare every cycle
   always @(negedge clk) begin : cmp
      int eff;
      bit low;
      if (rst_n && !finished) begin
         eff = (m_num > m_den) ? m_den : m_num;
         low = (q.size() > 0) && (q[0] == 1'b0) && (m_cnt < eff);
         chk(cur_req, "ir_tx_n vs model", int'(ir_tx_n), int'(!low));
         chk("R8", "irq vs model", int'(irq), int'(m_ie && !m_full));
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_stat(output logic [7:0] v);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = 3'd2;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   initial begin
      logic [7:0] st;
      bit seen;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      chk("R12", "ir_tx_n after reset", int'(ir_tx_n), 1);
      chk("R12", "irq after reset", int'(irq), 0);
      rd_stat(st);
      chk("R12", "status after reset", int'(st), 8'h10);

      // R11 write while disabled is held
      cur_req = "R11";
      low_cnt = 0;
      wr(3'd0, 8'hA5);
      repeat (40) @(negedge clk);
      rd_stat(st);
      chk("R11", "status with held byte", int'(st), 8'h00);
      chk("R11", "low cycles while disabled", low_cnt, 0);

      // R1 R2 R4 R7 R8 R9 default width, back-to-back
      cur_req = "R1 R2 R4 R9";
      low_cnt = 0;
      wr(3'd1, 8'h03);
      seen = 1'b0;
      for (int i = 0; i < 20 && !seen; i++) begin
         rd_stat(st);
         seen = st[4];
      end
      chk("R7", "buffer empty after transfer", int'(seen), 1);
      chk("R8", "irq with empty buffer", int'(irq), 1);
      wr(3'd0, 8'h3C);
      chk("R8", "irq with full buffer", int'(irq), 0);
      repeat (400) @(negedge clk);
      chk("R3", "low cycles for A5 then 3C", low_cnt, 20);
      rd_stat(st);
      chk("R10", "status after frames", int'(st), 8'h30);
      rd_stat(st);
      chk("R10", "status after clearing read", int'(st), 8'h10);

      // R5 3/16 width with pulse tick at 2x
      cur_req = "R5";
      wr(3'd1, 8'h00);
      bdiv = 2; kmul = 2;
      wr(3'd3, 8'd16);
      wr(3'd4, 8'd3);
      wr(3'd1, 8'h01);
      low_cnt = 0;
      wr(3'd0, 8'h00);
      repeat (250) @(negedge clk);
      chk("R5", "low cycles 3/16 width", low_cnt, 27);

      // R5 1/64 width with pulse tick at 8x
      wr(3'd1, 8'h00);
      bdiv = 8; kmul = 8;
      wr(3'd3, 8'd64);
      wr(3'd4, 8'd1);
      wr(3'd1, 8'h01);
      low_cnt = 0;
      wr(3'd0, 8'h0F);
      repeat (720) @(negedge clk);
      chk("R5", "low cycles 1/64 width", low_cnt, 5);

      // R6 clamps
      cur_req = "R6";
      wr(3'd1, 8'h00);
      bdiv = 2; kmul = 1;
      wr(3'd3, 8'd8);
      wr(3'd4, 8'd0);
      wr(3'd1, 8'h01);
      low_cnt = 0;
      wr(3'd0, 8'h00);
      repeat (250) @(negedge clk);
      chk("R6", "low cycles numerator 0", low_cnt, 0);
      wr(3'd4, 8'd20);
      low_cnt = 0;
      wr(3'd0, 8'hFF);
      repeat (250) @(negedge clk);
      chk("R6", "low cycles oversized numerator", low_cnt, 16);

      // R11 disable mid-frame, byte held until enable
      cur_req = "R11";
      wr(3'd4, 8'd1);
      wr(3'd0, 8'h00);
      repeat (40) @(negedge clk);
      wr(3'd1, 8'h00);
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         chk("R11", "output while disabled", int'(ir_tx_n), 1);
      end
      wr(3'd0, 8'h55);
      rd_stat(st);
      chk("R11", "buffer-empty while disabled", int'(st[4]), 0);
      low_cnt = 0;
      wr(3'd1, 8'h01);
      repeat (250) @(negedge clk);
      chk("R11", "low cycles for held 55", low_cnt, 10);

      summary();
   end
endmodule